// File: doc/BRIEF.md
# Line code violation detector and counter

This block watches a dual-rail bipolar receive stream, one symbol per receive clock, on a positive-pulse rail and a negative-pulse rail. It tracks mark polarity and zero runs and raises one-cycle event flags for bipolar violations, code violations and excessive-zero runs. The rules that apply depend on two mode inputs: the line standard (E1 or T1) and the coding (plain AMI, or zero substitution, which means HDB3 on E1 and B8ZS on T1).

A source-select vector chooses which events feed a saturating error counter. An external PRBS error strobe is one of the four sources. A latch-and-clear strobe copies the running count into a readable high-byte and low-byte pair and restarts the count in the same clock, so no event goes missing between two reads. Each substitution code is recognised as its violation symbol arrives. The block uses no lookahead and adds no latency to the stream.

Top module: `lcv_monitor`

## Requirements
- R1: A mark (pos_i or neg_i high) whose polarity equals that of the previous mark is a bipolar violation, even with zeros between the two marks. With coding_ami_i=1 every such violation raises bpv_o for one cycle, in the clock after the violating symbol is sampled. The first mark after reset is never a violation.
- R2: A symbol with pos_i and neg_i both high counts as one positive mark.
- R3: With mode_t1_i=0 and coding_ami_i=0 (HDB3), a violation is excused and raises no bpv_o in two cases: it follows exactly three zeros, or it follows exactly two zeros after a mark that was not itself a violation.
- R4: With mode_t1_i=1 and coding_ami_i=0 (B8ZS), the pattern 000VB0VB is excused as it arrives. The first V follows exactly three zeros. It is then followed by one non-violating mark, one zero, and a second V, which is also excused.
- R5: With mode_t1_i=0 and coding_ami_i=0, a violation whose polarity equals that of the previous violation raises cv_o, whether or not either violation was excused. cv_o never rises in any other mode.
- R6: With mode_t1_i=0, exz_o rises once per zero run, for the 4th consecutive zero only.
- R7: With mode_t1_i=1, exz_o rises once per zero run: at the 16th zero with coding_ami_i=1, and at the 8th zero with coding_ami_i=0.
- R8: With mode_t1_i=1, every bpv_o pulse is accompanied by an exz_o pulse.
- R9: In each clock in which at least one selected source fires, the counter increments by exactly one. The sources are bpv with sel_bpv_i, cv with sel_cv_i, exz with sel_exz_i, and prbs_err_i with sel_prbs_i. Sources that are not selected have no effect.
- R10: latch_i copies the count, including any event in that same clock, to cnt_hi_o (bits 15:8) and cnt_lo_o (bits 7:0), and clears the running count. The outputs change only on latch_i.
- R11: The count saturates at 0xFFFF and does not wrap.
- R12: Reset clears the count, the read registers, all event flags and the mark history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one line symbol per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_i | input | 1 | Positive-pulse rail |
| neg_i | input | 1 | Negative-pulse rail |
| mode_t1_i | input | 1 | 1 = T1 line rules, 0 = E1 line rules |
| coding_ami_i | input | 1 | 1 = AMI, 0 = zero substitution (HDB3/B8ZS) |
| sel_bpv_i | input | 1 | Count bipolar violations |
| sel_cv_i | input | 1 | Count code violations |
| sel_exz_i | input | 1 | Count excessive-zero events |
| sel_prbs_i | input | 1 | Count PRBS error strobes |
| prbs_err_i | input | 1 | External PRBS bit-error strobe |
| latch_i | input | 1 | Copy count to read registers and clear it |
| bpv_o | output | 1 | Bipolar violation event |
| cv_o | output | 1 | Code violation event |
| exz_o | output | 1 | Excessive-zero event |
| cnt_hi_o | output | CNT_W/2 | Latched count, high byte |
| cnt_lo_o | output | CNT_W/2 | Latched count, low byte |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and zero thresholds of 4, 16 and 8. With these values every mode's run threshold can be reached with short directed zero runs, and the bench checks the clock after each threshold to show that a run fires only once. With a 16-bit counter, saturation lies within about 66 thousand cycles of a held PRBS strobe, so the clamp at 0xFFFF is exercised directly rather than through a reduced width.

// File: rtl/lcv_pkg.sv
package lcv_pkg;

    // Polarity and substitution tracking state of the line decoder
    typedef struct packed {
        logic       have_mark;   // a mark has been seen since reset
        logic       last_neg;    // polarity of the last mark
        logic       last_viol;   // the last mark was a violation
        logic       have_v;      // a violation has been seen since reset
        logic       last_v_neg;  // polarity of the last violation
        logic [2:0] zrun;        // zeros since last mark, saturating
        logic [1:0] b8_ph;       // progress through the B8ZS pattern
    } lcv_track_t;

    typedef struct packed {
        logic bpv;
        logic cv;
        logic exz;
    } lcv_flags_t;

    localparam logic [1:0] B8_IDLE  = 2'd0;
    localparam logic [1:0] B8_GOT_V = 2'd1;
    localparam logic [1:0] B8_GOT_B = 2'd2;
    localparam logic [1:0] B8_GOT_Z = 2'd3;

endpackage

// File: rtl/lcv_line_decode.sv
module lcv_line_decode
    import lcv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    input  logic neg_i,
    input  logic mode_t1_i,
    input  logic coding_ami_i,
    output logic mark_o,
    output logic bpv_o,
    output logic cv_o
);

    lcv_track_t st_d, st_q;

    logic mark, is_neg, viol, hdb3_ok, b8_first, b8_second, excused;

    always_comb begin
        mark     = pos_i | neg_i;
        is_neg   = neg_i & ~pos_i;          // both rails high -> positive
        viol     = mark & st_q.have_mark & (is_neg == st_q.last_neg);
        hdb3_ok  = (st_q.zrun == 3'd3) | ((st_q.zrun == 3'd2) & ~st_q.last_viol);
        b8_first = (st_q.zrun == 3'd3);
        b8_second = (st_q.b8_ph == B8_GOT_Z) & (st_q.zrun == 3'd1);
        excused  = ~coding_ami_i & viol &
                   (mode_t1_i ? (b8_first | b8_second) : hdb3_ok);

        bpv_o  = viol & ~excused;
        cv_o   = ~mode_t1_i & ~coding_ami_i & viol & st_q.have_v &
                 (is_neg == st_q.last_v_neg);
        mark_o = mark;

        st_d = st_q;
        if (mark) begin
            st_d.have_mark = 1'b1;
            st_d.last_neg  = is_neg;
            st_d.last_viol = viol;
            st_d.zrun      = 3'd0;
        end else if (st_q.zrun != 3'd7) begin
            st_d.zrun = st_q.zrun + 3'd1;
        end
        if (viol) begin
            st_d.have_v     = 1'b1;
            st_d.last_v_neg = is_neg;
        end

        st_d.b8_ph = B8_IDLE;
        unique case (st_q.b8_ph)
            B8_IDLE:  if (mode_t1_i & ~coding_ami_i & viol & b8_first)
                          st_d.b8_ph = B8_GOT_V;
            B8_GOT_V: if (mark & ~viol) st_d.b8_ph = B8_GOT_B;
            B8_GOT_B: if (~mark)        st_d.b8_ph = B8_GOT_Z;
            default:  st_d.b8_ph = B8_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/lcv_zero_run.sv
module lcv_zero_run #(
    parameter int E1_EXZ     = 4,
    parameter int T1_AMI_EXZ = 16,
    parameter int T1_SUB_EXZ = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_i,
    input  logic mode_t1_i,
    input  logic coding_ami_i,
    output logic hit_o
);

    localparam int ZMAX_A = (E1_EXZ > T1_SUB_EXZ) ? E1_EXZ : T1_SUB_EXZ;
    localparam int ZMAX   = (ZMAX_A > T1_AMI_EXZ) ? ZMAX_A : T1_AMI_EXZ;
    localparam int ZW     = $clog2(ZMAX + 1);

    logic [ZW-1:0] zrun_d, zrun_q;
    logic [ZW:0]   thr, nxt;

    always_comb begin
        if (mode_t1_i) thr = coding_ami_i ? (ZW+1)'(T1_AMI_EXZ) : (ZW+1)'(T1_SUB_EXZ);
        else           thr = (ZW+1)'(E1_EXZ);
        nxt   = {1'b0, zrun_q} + {{ZW{1'b0}}, 1'b1};
        hit_o = ~mark_i & (nxt == thr);
        if (mark_i)             zrun_d = '0;
        else if (&zrun_q)       zrun_d = zrun_q;
        else                    zrun_d = nxt[ZW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zrun_q <= '0;
        else        zrun_q <= zrun_d;
    end

endmodule

// File: rtl/lcv_err_counter.sv
module lcv_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             latch_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] hold_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
    } ctr_t;

    ctr_t             c_d, c_q;
    logic [CNT_W-1:0] sum;

    always_comb begin
        sum = (inc_i && !(&c_q.cnt)) ? c_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1} : c_q.cnt;
        c_d = c_q;
        if (latch_i) begin
            c_d.hold = sum;
            c_d.cnt  = '0;
        end else begin
            c_d.cnt  = sum;
        end
        cnt_o  = c_q.cnt;
        hold_o = c_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

endmodule

// File: rtl/lcv_monitor.sv
module lcv_monitor
    import lcv_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int E1_EXZ     = 4,
    parameter int T1_AMI_EXZ = 16,
    parameter int T1_SUB_EXZ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pos_i,
    input  logic               neg_i,
    input  logic               mode_t1_i,
    input  logic               coding_ami_i,
    input  logic               sel_bpv_i,
    input  logic               sel_cv_i,
    input  logic               sel_exz_i,
    input  logic               sel_prbs_i,
    input  logic               prbs_err_i,
    input  logic               latch_i,
    output logic               bpv_o,
    output logic               cv_o,
    output logic               exz_o,
    output logic [CNT_W/2-1:0] cnt_hi_o,
    output logic [CNT_W/2-1:0] cnt_lo_o
);

    localparam int HALF = CNT_W / 2;

    logic             mark, bpv_now, cv_now, zhit, inc;
    logic [CNT_W-1:0] cnt_now, hold;
    lcv_flags_t       ev, fl_d, fl_q;

    lcv_line_decode u_dec (
        .clk(clk), .rst_n(rst_n), .pos_i(pos_i), .neg_i(neg_i),
        .mode_t1_i(mode_t1_i), .coding_ami_i(coding_ami_i),
        .mark_o(mark), .bpv_o(bpv_now), .cv_o(cv_now)
    );

    lcv_zero_run #(
        .E1_EXZ(E1_EXZ), .T1_AMI_EXZ(T1_AMI_EXZ), .T1_SUB_EXZ(T1_SUB_EXZ)
    ) u_zr (
        .clk(clk), .rst_n(rst_n), .mark_i(mark),
        .mode_t1_i(mode_t1_i), .coding_ami_i(coding_ami_i), .hit_o(zhit)
    );

    always_comb begin
        ev.bpv = bpv_now;
        ev.cv  = cv_now;
        ev.exz = zhit | (mode_t1_i & bpv_now);
        inc    = (sel_bpv_i & ev.bpv) | (sel_cv_i & ev.cv) |
                 (sel_exz_i & ev.exz) | (sel_prbs_i & prbs_err_i);
        fl_d   = ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    lcv_err_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .inc_i(inc), .latch_i(latch_i),
        .cnt_o(cnt_now), .hold_o(hold)
    );

    assign bpv_o    = fl_q.bpv;
    assign cv_o     = fl_q.cv;
    assign exz_o    = fl_q.exz;
    assign cnt_hi_o = hold[CNT_W-1:HALF];
    assign cnt_lo_o = hold[HALF-1:0];

endmodule

// File: rtl/lcv_monitor_chk.sv
module lcv_monitor_chk #(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pos_i,
    input logic               neg_i,
    input logic               mode_t1_i,
    input logic               coding_ami_i,
    input logic               latch_i,
    input logic               bpv_o,
    input logic               cv_o,
    input logic               exz_o,
    input logic [CNT_W/2-1:0] cnt_hi_o,
    input logic [CNT_W/2-1:0] cnt_lo_o,
    input logic [CNT_W-1:0]   cnt_now
);

    AST_BPV_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        bpv_o |-> $past(pos_i || neg_i)); // R1

    AST_CV_ONLY_E1_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        cv_o |-> $past(!mode_t1_i && !coding_ami_i)); // R5

    AST_T1_BPV_EXZ: assert property (@(posedge clk) disable iff (!rst_n)
        (bpv_o && $past(mode_t1_i)) |-> exz_o); // R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(latch_i) |-> $stable({cnt_hi_o, cnt_lo_o})); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(&cnt_now) && !$past(latch_i)) |-> (&cnt_now)); // R11

endmodule

bind lcv_monitor lcv_monitor_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_lcv_monitor.sv
`timescale 1ns/1ps
module sim_lcv_monitor;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pos = 1'b0, neg = 1'b0, t1 = 1'b0, ami = 1'b1;
    logic s_bpv = 1'b0, s_cv = 1'b0, s_exz = 1'b0, s_prbs = 1'b0;
    logic prbs = 1'b0, latch = 1'b0;
    logic bpv, cv, exz;
    logic [7:0] hi, lo;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lcv_monitor u0 (
        .clk(clk), .rst_n(rst_n), .pos_i(pos), .neg_i(neg),
        .mode_t1_i(t1), .coding_ami_i(ami),
        .sel_bpv_i(s_bpv), .sel_cv_i(s_cv), .sel_exz_i(s_exz), .sel_prbs_i(s_prbs),
        .prbs_err_i(prbs), .latch_i(latch),
        .bpv_o(bpv), .cv_o(cv), .exz_o(exz), .cnt_hi_o(hi), .cnt_lo_o(lo)
    );

    // {clr, t1, ami, pos, neg, exp_bpv, exp_cv, exp_exz}
    localparam int NV = 46;
    localparam logic [7:0] VEC [NV] = '{
        // E1 AMI: R1 violations, R6 four-zero run
        8'b1_0_1_10_000, 8'b0_0_1_01_000, 8'b0_0_1_10_000, 8'b0_0_1_10_100,
        8'b0_0_1_00_000, 8'b0_0_1_00_000, 8'b0_0_1_00_000, 8'b0_0_1_00_001,
        8'b0_0_1_00_000, 8'b0_0_1_01_000, 8'b0_0_1_00_000, 8'b0_0_1_01_100,
        // E1 HDB3: R3 000V and B00V excused, R5 code violation
        8'b1_0_0_10_000, 8'b0_0_0_00_000, 8'b0_0_0_00_000, 8'b0_0_0_00_000,
        8'b0_0_0_10_000, 8'b0_0_0_01_000, 8'b0_0_0_00_000, 8'b0_0_0_00_000,
        8'b0_0_0_01_000, 8'b0_0_0_10_000, 8'b0_0_0_00_000, 8'b0_0_0_00_000,
        8'b0_0_0_00_000, 8'b0_0_0_10_000, 8'b0_0_0_10_110,
        // T1 AMI: R8
        8'b1_1_1_10_000, 8'b0_1_1_10_101, 8'b0_1_1_01_000,
        // T1 B8ZS: R4 000VB0VB excused, then real violations with R8
        8'b1_1_0_10_000, 8'b0_1_0_00_000, 8'b0_1_0_00_000, 8'b0_1_0_00_000,
        8'b0_1_0_10_000, 8'b0_1_0_01_000, 8'b0_1_0_00_000, 8'b0_1_0_01_000,
        8'b0_1_0_10_000, 8'b0_1_0_01_000, 8'b0_1_0_01_101, 8'b0_1_0_00_000,
        8'b0_1_0_01_101,
        // E1 AMI: R2 both rails form a positive mark
        8'b1_0_1_10_000, 8'b0_0_1_11_100, 8'b0_0_1_01_000
    };

    function automatic string tag_of(int i);
        if (i < 12)      return "R1 R6";
        else if (i < 27) return "R3 R5";
        else if (i < 30) return "R8";
        else if (i < 43) return "R4 R8";
        else             return "R2";
    endfunction

    task automatic check(string tag, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pos = 1'b0; neg = 1'b0; latch = 1'b0; prbs = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic sym(logic p, logic n);
        pos = p; neg = n;
        tick();
    endtask

    task automatic read_count(string tag, int exp);
        pos = 1'b0; neg = 1'b0; prbs = 1'b0; latch = 1'b1;
        tick();
        latch = 1'b0;
        check(tag, {hi, lo}, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        do_reset();
        check("R12 flags", {bpv, cv, exz}, 0);
        check("R12 count", {hi, lo}, 0);
        t1 = 1'b0; ami = 1'b1;
        sym(1'b1, 1'b0);
        check("R12 first mark", bpv, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][7]) do_reset();
            t1 = VEC[i][6]; ami = VEC[i][5];
            sym(VEC[i][4], VEC[i][3]);
            check({tag_of(i), " bpv"}, bpv, VEC[i][2]);
            check({tag_of(i), " cv"},  cv,  VEC[i][1]);
            check({tag_of(i), " exz"}, exz, VEC[i][0]);
        end

        // R7: T1 AMI run of 20 zeros, exz only at the 16th
        t1 = 1'b1; ami = 1'b1;
        do_reset();
        sym(1'b1, 1'b0);
        for (int z = 1; z <= 20; z++) begin
            sym(1'b0, 1'b0);
            check("R7 ami run", exz, (z == 16) ? 1 : 0);
        end

        // R7: T1 B8ZS run of 12 zeros, exz only at the 8th
        ami = 1'b0;
        do_reset();
        sym(1'b1, 1'b0);
        for (int z = 1; z <= 12; z++) begin
            sym(1'b0, 1'b0);
            check("R7 b8zs run", exz, (z == 8) ? 1 : 0);
        end

        // R9: only bpv selected, two violations counted, exz ignored
        t1 = 1'b0; ami = 1'b1;
        do_reset();
        s_bpv = 1'b1;
        sym(1'b1, 1'b0); sym(1'b1, 1'b0); sym(1'b1, 1'b0);
        for (int z = 0; z < 5; z++) sym(1'b0, 1'b0);
        read_count("R9 bpv select", 2);
        s_bpv = 1'b0;

        // R9: unselected prbs strobes have no effect
        prbs = 1'b1;
        for (int k = 0; k < 5; k++) tick();
        read_count("R9 unselected", 0);

        // R10: event in the latch cycle is kept, count restarts
        s_prbs = 1'b1;
        prbs = 1'b1; tick(); tick();
        latch = 1'b1; tick();
        latch = 1'b0; prbs = 1'b0;
        check("R10 latch cycle", {hi, lo}, 3);
        tick();
        check("R10 hold stable", {hi, lo}, 3);
        read_count("R10 cleared", 0);

        // R11: saturation
        prbs = 1'b1;
        for (int k = 0; k < 70000; k++) tick();
        read_count("R11 saturate", 16'hFFFF);
        check("R11 high byte", hi, 8'hFF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule